// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-port memory and watches the enable and address of each port. When both ports select the same location in the same cycle, it decides which port keeps the location and drives an active-low busy indication to the other. Any write that the losing port requests is blocked inside the block. The decision looks only at enables and addresses. A read and a write are arbitrated the same way.

The port whose enable and address were already steady wins. A port counts as newly arriving in a cycle when its enable has just gone active, or when it is enabled and its address differs from the previous cycle. Once a port holds the location, it keeps it for as long as the collision continues.

In slave mode the block makes no decision of its own. Its busy outputs stay high, and each port's busy input acts only as a write inhibit. Several slices of a wide word can then follow the decision of a single master. The design is synchronous to one clock. The busy outputs and write enables are combinational from the current inputs and the registered arrival history.

Top module: `collision_arbiter`

## Requirements
- R1: Both busy outputs are high (1) unless both ports are enabled and their full addresses are equal.
- R2: In master mode, when a collision starts and exactly one port is newly arriving, that port gets busy low (0) in the same cycle and the steady port stays high. A port is newly arriving when its enable rose this cycle, or when it is enabled and its address differs from last cycle.
- R3: Both busy outputs are never low in the same cycle.
- R4: The write request inputs have no effect on which port is busy.
- R5: In master mode each write enable output equals that port's write request ANDed with its own busy output being high. The busy input pins are ignored in this mode.
- R6: In slave mode (slave_mode = 1) both busy outputs are held high. Each write enable equals its write request ANDed with that port's busy input being high.
- R7: Busy returns high in the same cycle in which the addresses stop matching or either enable goes low.
- R8: If a collision starts with both ports newly arriving in the same cycle, the left port wins and the right busy goes low.
- R9: While a collision persists from cycle to cycle, the same port stays busy, even when neither port is newly arriving. If the losing port moves away and then returns, the steady port wins again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_mode | input | 1 | 1: busy pins act as write-inhibit inputs |
| left_en | input | 1 | Left port enable, active high |
| left_addr | input | ADDR_W | Left port address |
| left_wr_req | input | 1 | Left port write request |
| left_busy_in_n | input | 1 | Left write inhibit in slave mode, active low |
| right_en | input | 1 | Right port enable, active high |
| right_addr | input | ADDR_W | Right port address |
| right_wr_req | input | 1 | Right port write request |
| right_busy_in_n | input | 1 | Right write inhibit in slave mode, active low |
| left_busy_n | output | 1 | Left busy indication, active low |
| right_busy_n | output | 1 | Right busy indication, active low |
| left_wr_en | output | 1 | Gated left write enable |
| right_wr_en | output | 1 | Gated right write enable |

## Verification
The hardest state to reach from the ports is an ongoing collision in which the earlier winner would lose if the decision were made fresh. In that state both ports have been steady for a cycle, so a stateless tie-break would favour the left port even though the right port holds the location. The stimulus reaches it in two steps. The right port is parked on an address first, and the left port then moves onto that address. Holding both steady for one more cycle then shows whether the left port stays busy. A second sequence moves the losing port away for one cycle and brings it back, to show that the steady port wins the new collision.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    localparam int NUM_PORTS = 2;
    localparam int IDX_LEFT  = 0;
    localparam int IDX_RIGHT = 1;
endpackage

// File: rtl/port_tracker.sv
module port_tracker #(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              fresh
);
    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
    } hist_t;

    hist_t hist_d, hist_q;

    always_comb begin
        hist_d      = hist_q;
        hist_d.en   = en;
        hist_d.addr = addr;
        // newly arriving: enable just rose, or address moved while enabled
        fresh = en && (!hist_q.en || (addr != hist_q.addr));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end
endmodule

// File: rtl/owner_arbiter.sv
module owner_arbiter
    import arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   match,
    input  logic   fresh_left,
    input  logic   fresh_right,
    output owner_e owner_now
);
    typedef struct packed {
        owner_e owner;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!match) begin
            st_d.owner = OWN_NONE;
        end else if (st_q.owner == OWN_NONE) begin
            // the steady port takes the location; a tie goes left
            if (fresh_left && !fresh_right) begin
                st_d.owner = OWN_RIGHT;
            end else begin
                st_d.owner = OWN_LEFT;
            end
        end
        owner_now = st_d.owner;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.owner <= OWN_NONE;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/write_gate.sv
module write_gate (
    input  logic slave_mode,
    input  logic lose,
    input  logic busy_in_n,
    input  logic wr_req,
    output logic busy_n,
    output logic wr_en
);
    logic blocked;

    always_comb begin
        if (slave_mode) begin
            busy_n  = 1'b1;
            blocked = !busy_in_n;
        end else begin
            busy_n  = !lose;
            blocked = lose;
        end
        wr_en = wr_req && !blocked;
    end
endmodule

// File: rtl/collision_arbiter.sv
module collision_arbiter
    import arb_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              left_en,
    input  logic [ADDR_W-1:0] left_addr,
    input  logic              left_wr_req,
    input  logic              left_busy_in_n,
    input  logic              right_en,
    input  logic [ADDR_W-1:0] right_addr,
    input  logic              right_wr_req,
    input  logic              right_busy_in_n,
    output logic              left_busy_n,
    output logic              right_busy_n,
    output logic              left_wr_en,
    output logic              right_wr_en
);
    logic [NUM_PORTS-1:0]             en_v;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_v;
    logic [NUM_PORTS-1:0]             wr_req_v;
    logic [NUM_PORTS-1:0]             busy_in_v;
    logic [NUM_PORTS-1:0]             fresh_v;
    logic [NUM_PORTS-1:0]             lose_v;
    logic [NUM_PORTS-1:0]             busy_v;
    logic [NUM_PORTS-1:0]             wr_en_v;
    logic                             match;
    owner_e                           owner_now;

    always_comb begin
        en_v[IDX_LEFT]       = left_en;
        en_v[IDX_RIGHT]      = right_en;
        addr_v[IDX_LEFT]     = left_addr;
        addr_v[IDX_RIGHT]    = right_addr;
        wr_req_v[IDX_LEFT]   = left_wr_req;
        wr_req_v[IDX_RIGHT]  = right_wr_req;
        busy_in_v[IDX_LEFT]  = left_busy_in_n;
        busy_in_v[IDX_RIGHT] = right_busy_in_n;
        match                = left_en && right_en && (left_addr == right_addr);
        lose_v[IDX_LEFT]     = (owner_now == OWN_RIGHT);
        lose_v[IDX_RIGHT]    = (owner_now == OWN_LEFT);
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        port_tracker #(.ADDR_W(ADDR_W)) u_track (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_v[p]),
            .addr  (addr_v[p]),
            .fresh (fresh_v[p])
        );

        write_gate u_gate (
            .slave_mode (slave_mode),
            .lose       (lose_v[p]),
            .busy_in_n  (busy_in_v[p]),
            .wr_req     (wr_req_v[p]),
            .busy_n     (busy_v[p]),
            .wr_en      (wr_en_v[p])
        );
    end

    owner_arbiter u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .match       (match),
        .fresh_left  (fresh_v[IDX_LEFT]),
        .fresh_right (fresh_v[IDX_RIGHT]),
        .owner_now   (owner_now)
    );

    assign left_busy_n  = busy_v[IDX_LEFT];
    assign right_busy_n = busy_v[IDX_RIGHT];
    assign left_wr_en   = wr_en_v[IDX_LEFT];
    assign right_wr_en  = wr_en_v[IDX_RIGHT];
endmodule

// File: rtl/arb_checks.sv
module arb_checks #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slave_mode,
    input logic              left_en,
    input logic [ADDR_W-1:0] left_addr,
    input logic              left_wr_req,
    input logic              left_busy_in_n,
    input logic              right_en,
    input logic [ADDR_W-1:0] right_addr,
    input logic              right_wr_req,
    input logic              right_busy_in_n,
    input logic              left_busy_n,
    input logic              right_busy_n,
    input logic              left_wr_en,
    input logic              right_wr_en
);
    logic hit;
    assign hit = left_en && right_en && (left_addr == right_addr);

    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (left_busy_n && right_busy_n));

    p_later_loses_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && hit && $past(left_en) && ($past(left_addr) == left_addr)
         && !$past(right_en)) |-> !right_busy_n);

    p_never_both_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!left_busy_n && !right_busy_n));

    p_master_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !slave_mode |-> ((left_wr_en == (left_wr_req && left_busy_n)) &&
                         (right_wr_en == (right_wr_req && right_busy_n))));

    p_slave_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |-> (left_busy_n && right_busy_n &&
                        (left_wr_en == (left_wr_req && left_busy_in_n)) &&
                        (right_wr_en == (right_wr_req && right_busy_in_n))));

    p_tie_left_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && hit && !$past(left_en) && !$past(right_en)) |-> !right_busy_n);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && $past(!slave_mode) && hit && $past(hit) && $past(!left_busy_n))
        |-> !left_busy_n);
endmodule

bind collision_arbiter arb_checks #(.ADDR_W(ADDR_W)) u_arb_checks (
    .clk             (clk),
    .rst_n           (rst_n),
    .slave_mode      (slave_mode),
    .left_en         (left_en),
    .left_addr       (left_addr),
    .left_wr_req     (left_wr_req),
    .left_busy_in_n  (left_busy_in_n),
    .right_en        (right_en),
    .right_addr      (right_addr),
    .right_wr_req    (right_wr_req),
    .right_busy_in_n (right_busy_in_n),
    .left_busy_n     (left_busy_n),
    .right_busy_n    (right_busy_n),
    .left_wr_en      (left_wr_en),
    .right_wr_en     (right_wr_en)
);

// File: tb/collision_arbiter_bench.sv
module collision_arbiter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 17;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              slave_mode = 1'b0;
    logic              left_en = 1'b0, right_en = 1'b0;
    logic [ADDR_W-1:0] left_addr = '0, right_addr = '0;
    logic              left_wr_req = 1'b0, right_wr_req = 1'b0;
    logic              left_busy_in_n = 1'b1, right_busy_in_n = 1'b1;
    logic              left_busy_n, right_busy_n, left_wr_en, right_wr_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    collision_arbiter #(.ADDR_W(ADDR_W)) u_collision_arbiter (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .left_en(left_en), .left_addr(left_addr), .left_wr_req(left_wr_req),
        .left_busy_in_n(left_busy_in_n),
        .right_en(right_en), .right_addr(right_addr), .right_wr_req(right_wr_req),
        .right_busy_in_n(right_busy_in_n),
        .left_busy_n(left_busy_n), .right_busy_n(right_busy_n),
        .left_wr_en(left_wr_en), .right_wr_en(right_wr_en)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    // drive one cycle at the falling edge, settle, then checks may follow
    task automatic apply(input logic sm, input logic lbi, input logic rbi,
                         input logic le, input int la, input logic lw,
                         input logic re, input int ra, input logic rw);
        @(negedge clk);
        slave_mode = sm; left_busy_in_n = lbi; right_busy_in_n = rbi;
        left_en = le; left_addr = ADDR_W'(la); left_wr_req = lw;
        right_en = re; right_addr = ADDR_W'(ra); right_wr_req = rw;
        #1;
    endtask

    task automatic idle();
        apply(0, 1, 1, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk("R1 reset left busy", left_busy_n, 1'b1);
        chk("R1 reset right busy", right_busy_n, 1'b1);
        chk("R5 reset left wr_en", left_wr_en, 1'b0);
        chk("R5 reset right wr_en", right_wr_en, 1'b0);
    endtask

    task automatic t_disjoint();
        idle();
        apply(0, 1, 1, 1, 5, 1, 1, 6, 1);
        chk("R1 distinct addr left", left_busy_n, 1'b1);
        chk("R1 distinct addr right", right_busy_n, 1'b1);
        chk("R5 distinct addr right wr", right_wr_en, 1'b1);
        apply(0, 1, 1, 1, 5, 0, 0, 5, 1);
        chk("R1 right disabled left", left_busy_n, 1'b1);
        chk("R1 right disabled right", right_busy_n, 1'b1);
    endtask

    task automatic t_left_first();
        idle();
        apply(0, 1, 1, 1, 10, 0, 0, 0, 0);
        apply(0, 1, 1, 1, 10, 1, 1, 10, 1);
        chk("R2 later right busy", right_busy_n, 1'b0);
        chk("R2 earlier left free", left_busy_n, 1'b1);
        chk("R5 right write blocked", right_wr_en, 1'b0);
        chk("R5 left write passes", left_wr_en, 1'b1);
        apply(0, 1, 1, 1, 10, 0, 1, 10, 0);
        chk("R4 reads same right busy", right_busy_n, 1'b0);
        chk("R4 reads same left busy", left_busy_n, 1'b1);
        apply(0, 1, 1, 1, 10, 1, 1, 10, 1);
        chk("R9 hold right busy", right_busy_n, 1'b0);
        apply(0, 1, 1, 0, 10, 1, 1, 10, 1);
        chk("R7 enable drop right", right_busy_n, 1'b1);
        chk("R7 enable drop right wr", right_wr_en, 1'b1);
    endtask

    task automatic t_right_first();
        idle();
        apply(0, 1, 1, 1, 21, 1, 1, 20, 1);
        apply(0, 1, 1, 1, 20, 1, 1, 20, 1);
        chk("R2 moved left busy", left_busy_n, 1'b0);
        chk("R2 steady right free", right_busy_n, 1'b1);
        chk("R5 left write blocked", left_wr_en, 1'b0);
        apply(0, 1, 1, 1, 20, 1, 1, 20, 1);
        chk("R9 steady both left still busy", left_busy_n, 1'b0);
        chk("R9 steady both right free", right_busy_n, 1'b1);
        apply(0, 1, 1, 1, 22, 1, 1, 20, 1);
        chk("R7 addr mismatch left", left_busy_n, 1'b1);
    endtask

    task automatic t_tie_and_rematch();
        idle();
        apply(0, 1, 1, 1, 30, 1, 1, 30, 1);
        chk("R8 tie right busy", right_busy_n, 1'b0);
        chk("R8 tie left free", left_busy_n, 1'b1);
        chk("R3 tie not both low", left_busy_n | right_busy_n, 1'b1);
        apply(0, 1, 1, 1, 30, 1, 1, 31, 1);
        chk("R7 right moved away", right_busy_n, 1'b1);
        apply(0, 1, 1, 1, 30, 1, 1, 30, 1);
        chk("R9 rematch right busy", right_busy_n, 1'b0);
        chk("R9 rematch left free", left_busy_n, 1'b1);
    endtask

    task automatic t_slave();
        idle();
        apply(1, 1, 1, 1, 40, 1, 1, 40, 1);
        chk("R6 slave left busy high", left_busy_n, 1'b1);
        chk("R6 slave right busy high", right_busy_n, 1'b1);
        chk("R6 slave left wr", left_wr_en, 1'b1);
        chk("R6 slave right wr", right_wr_en, 1'b1);
        apply(1, 0, 1, 1, 40, 1, 1, 40, 1);
        chk("R6 slave left inhibited", left_wr_en, 1'b0);
        chk("R6 slave right passes", right_wr_en, 1'b1);
        apply(0, 0, 0, 1, 41, 1, 1, 42, 1);
        chk("R5 master ignores left pin", left_wr_en, 1'b1);
        chk("R5 master ignores right pin", right_wr_en, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_disjoint();
        t_left_first();
        t_right_first();
        t_tie_and_rematch();
        t_slave();
        idle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule